// File: doc/BRIEF.md
# Johnson-Ring Decade Counter with Decoded Outputs

This block counts advance events and shows the count as ten one-hot decoded lines, one of which is high at any time. The count is kept in a five-stage twisted-ring (Johnson) register that steps through ten codes before it repeats. Each decoded line is formed from two neighbouring ring bits. A carry line is taken from the inverted top ring bit. It is high for counts 0 to 4 and low for counts 5 to 9, so it rises as the count wraps from 9 back to 0. It can therefore act as the count strobe of a following stage.

The block runs on a fast system clock. Two slow external strobes, a count strobe and an active-low enable, each pass through a two-flop synchronizer. An edge classifier then compares each synchronized value with its value one cycle earlier. An advance occurs on a rising count strobe while the enable is low. An advance also occurs on a falling enable while the count strobe is high. A clear input forces count 0 at once, without waiting for the clock. Its release is synchronized, so the ring restarts cleanly.

Ring states are named `J0` to `J9` (codes 00000, 00001, 00011, 00111, 01111, 11111, 11110, 11100, 11000, 10000). On an advance the ring takes transition `Jn -> Jn+1`, and it takes the wrap `J9 -> J0` after J9. Any other code takes the recovery transition `ILLEGAL -> J0` on the next advance. The edge classifier has the states `EV_NONE`, `EV_CLK_RISE` and `EV_EN_FALL`.

Top module: `decade_divider`

## Requirements
- R1: After reset or clear, `dec_out` is 10'b0000000001 (line 0 high) and `carry` is 1.
- R2: Exactly one bit of `dec_out` is high at all times after reset. Bit n is high when the count is n.
- R3: A rising `cnt_clk` while `cnt_en_n` is low advances the count by one. The count wraps from 9 to 0.
- R4: While `cnt_en_n` is high, changes on `cnt_clk` leave the count unchanged.
- R5: A falling `cnt_en_n` while `cnt_clk` is high advances the count by one.
- R6: A falling `cnt_clk` or a rising `cnt_en_n` leaves the count unchanged.
- R7: While `clear` is high, the count stays 0 whatever the strobes do. Strobe edges seen during the clear are not counted.
- R8: `carry` is 1 for counts 0 to 4 and 0 for counts 5 to 9, so it rises on the wrap from 9 to 0.
- R9: The ring register only ever holds one of the ten legal twisted-ring codes. An illegal code returns to count 0 on the next advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Active-high clear; asserted asynchronously, released synchronously |
| cnt_clk | input | 1 | Asynchronous count strobe |
| cnt_en_n | input | 1 | Asynchronous active-low count enable |
| dec_out | output | 10 | One-hot decoded count |
| carry | output | 1 | High for counts 0 to 4 |

## Verification
The bench targets these corner cases:
- A full wrap from 9 to 0. A design with a wrong ring step would skip or repeat a decoded line, or leave the carry low after the wrap.
- Toggling the count strobe while the enable is high. A design that ignores the enable would count here.
- Falling edges of the enable while the count strobe is high, and a count strobe rise together with an enable fall in the same cycle. A design that misses the second advance path stalls on these. A design that adds the two events counts twice.
- Pulsing the strobes while clear is held. A leaky clear would come out of reset at a nonzero count.

// File: rtl/decade_pkg.sv
package decade_pkg;
    localparam int RING_W      = 5;
    localparam int OUT_W       = 2 * RING_W;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [RING_W-1:0] {
        J0 = 5'b00000,
        J1 = 5'b00001,
        J2 = 5'b00011,
        J3 = 5'b00111,
        J4 = 5'b01111,
        J5 = 5'b11111,
        J6 = 5'b11110,
        J7 = 5'b11100,
        J8 = 5'b11000,
        J9 = 5'b10000
    } jstate_e;

    typedef enum logic [1:0] {
        EV_NONE     = 2'd0,
        EV_CLK_RISE = 2'd1,
        EV_EN_FALL  = 2'd2
    } event_e;
endpackage

// File: rtl/dc_sync.sv
module dc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dc_event.sv
module dc_event
    import decade_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clk_s,
    input  logic en_n_s,
    output logic advance
);
    logic   clk_d;
    logic   en_n_d;
    event_e kind;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_d  <= 1'b0;
            en_n_d <= 1'b1;
        end else begin
            clk_d  <= clk_s;
            en_n_d <= en_n_s;
        end
    end

    always_comb begin
        kind = EV_NONE;
        if (clk_s && !clk_d && !en_n_s) begin
            kind = EV_CLK_RISE;
        end else if (!en_n_s && en_n_d && clk_s) begin
            kind = EV_EN_FALL;
        end
    end

    assign advance = (kind != EV_NONE);
endmodule

// File: rtl/dc_ring.sv
module dc_ring
    import decade_pkg::*;
(
    input  logic             clk,
    input  logic             clr,
    input  logic             advance,
    output logic [RING_W-1:0] ring_o,
    output logic [OUT_W-1:0]  dec_o,
    output logic             carry_o
);
    jstate_e state_q;
    jstate_e state_d;

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            state_q <= J0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (advance) begin
            unique case (state_q)
                J0:      state_d = J1;
                J1:      state_d = J2;
                J2:      state_d = J3;
                J3:      state_d = J4;
                J4:      state_d = J5;
                J5:      state_d = J6;
                J6:      state_d = J7;
                J7:      state_d = J8;
                J8:      state_d = J9;
                J9:      state_d = J0;
                default: state_d = J0;
            endcase
        end
    end

    logic [RING_W-1:0] b;
    assign b = state_q;

    for (genvar i = 0; i < RING_W; i++) begin : g_dec
        if (i == 0) begin : g_edge
            assign dec_o[0]      = ~b[RING_W-1] & ~b[0];
            assign dec_o[RING_W] =  b[RING_W-1] &  b[0];
        end else begin : g_mid
            assign dec_o[i]        =  b[i-1] & ~b[i];
            assign dec_o[RING_W+i] =  b[i]   & ~b[i-1];
        end
    end

    assign carry_o = ~b[RING_W-1];
    assign ring_o  = b;
endmodule

// File: rtl/decade_divider.sv
module decade_divider
    import decade_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             cnt_clk,
    input  logic             cnt_en_n,
    output logic [OUT_W-1:0] dec_out,
    output logic             carry
);
    logic                   clk_s;
    logic                   en_n_s;
    logic                   advance;
    logic                   clr_async;
    logic                   clr_hold;
    logic [SYNC_STAGES-1:0] clr_q;
    logic [RING_W-1:0]      ring_q;

    assign clr_async = clear | ~rst_n;

    always_ff @(posedge clk or posedge clr_async) begin
        if (clr_async) begin
            clr_q <= '1;
        end else begin
            clr_q <= {clr_q[SYNC_STAGES-2:0], 1'b0};
        end
    end

    assign clr_hold = clr_q[SYNC_STAGES-1];

    dc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_clk (
        .clk(clk), .rst_n(rst_n), .d(cnt_clk), .q(clk_s)
    );

    dc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_en (
        .clk(clk), .rst_n(rst_n), .d(cnt_en_n), .q(en_n_s)
    );

    dc_event u_event (
        .clk(clk), .rst_n(rst_n), .clk_s(clk_s), .en_n_s(en_n_s), .advance(advance)
    );

    dc_ring u_ring (
        .clk(clk), .clr(clr_hold), .advance(advance),
        .ring_o(ring_q), .dec_o(dec_out), .carry_o(carry)
    );
endmodule

// File: rtl/decade_divider_chk.sv
module decade_divider_chk
    import decade_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             clear,
    input logic             clr_hold,
    input logic             advance,
    input logic [OUT_W-1:0] dec_out,
    input logic             carry,
    input logic [RING_W-1:0] ring
);
    // R2
    one_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dec_out) == 1);

    // R1
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (dec_out == 10'd1) && carry);

    // R3
    step_chk: assert property (@(posedge clk) disable iff (!rst_n || clear)
        (advance && !clr_hold) |=> dec_out == {$past(dec_out[OUT_W-2:0]), $past(dec_out[OUT_W-1])});

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n || clear)
        (!advance && !clr_hold) |=> $stable(dec_out));

    // R8
    carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry == (|dec_out[RING_W-1:0]));

    // R9
    legal_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ring[RING_W-2:0] ^ ring[RING_W-1:1]) <= 1);
endmodule

bind decade_divider decade_divider_chk u_chk (
    .clk(clk), .rst_n(rst_n), .clear(clear), .clr_hold(clr_hold),
    .advance(advance), .dec_out(dec_out), .carry(carry), .ring(ring_q)
);

// File: tb/decade_divider_test.sv
module decade_divider_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clear = 1'b0;
    logic       cnt_clk = 1'b0;
    logic       cnt_en_n = 1'b1;
    logic [9:0] dec_out;
    logic       carry;

    int checks = 0;
    int fails  = 0;
    int idx    = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    decade_divider uut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .cnt_clk(cnt_clk),
        .cnt_en_n(cnt_en_n), .dec_out(dec_out), .carry(carry)
    );

    function automatic logic [9:0] exp_dec(input int n);
        return 10'd1 << n;
    endfunction

    function automatic logic exp_adv(input logic pc, input logic pe, input logic nc, input logic ne);
        return (nc && !pc && !ne) || (!ne && pe && nc);
    endfunction

    task automatic check(input string tag);
        checks++;
        if (dec_out !== exp_dec(idx)) begin
            fails++;
            $display("FAIL %s dec_out actual=%b expected=%b", tag, dec_out, exp_dec(idx));
        end
        checks++;
        if (carry !== (idx < 5)) begin
            fails++;
            $display("FAIL R8 (%s) carry actual=%b expected=%b", tag, carry, (idx < 5));
        end
    endtask

    task automatic drive(input logic c, input logic e, input bit held, input string tag);
        logic a;
        @(negedge clk);
        a = exp_adv(cnt_clk, cnt_en_n, c, e);
        cnt_clk  = c;
        cnt_en_n = e;
        repeat (4) @(negedge clk);
        if (a && !held) idx = (idx + 1) % 10;
        if (!held) check(tag);
    endtask

    task automatic do_clear(input string tag);
        @(negedge clk);
        clear = 1'b1;
        #1;
        idx = 0;
        check(tag);
        @(negedge clk);
        clear = 1'b0;
        repeat (4) @(negedge clk);
        check(tag);
    endtask

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset");

        drive(1'b0, 1'b0, 0, "R6 enable fall with strobe low");
        for (int i = 0; i < 12; i++) begin
            drive(1'b1, 1'b0, 0, "R3 strobe rise");
            drive(1'b0, 1'b0, 0, "R6 strobe fall");
        end
        drive(1'b0, 1'b1, 0, "R6 enable rise");
        for (int i = 0; i < 3; i++) begin
            drive(1'b1, 1'b1, 0, "R4 strobe rise disabled");
            drive(1'b0, 1'b1, 0, "R4 strobe fall disabled");
        end
        drive(1'b1, 1'b1, 0, "R4 strobe high disabled");
        drive(1'b1, 1'b0, 0, "R5 enable fall strobe high");
        drive(1'b1, 1'b1, 0, "R6 enable rise strobe high");
        drive(1'b1, 1'b0, 0, "R5 enable fall again");
        drive(1'b0, 1'b1, 0, "R6 both release");
        drive(1'b1, 1'b0, 0, "R5 rise and fall together");

        @(negedge clk);
        clear = 1'b1;
        #1;
        idx = 0;
        check("R7 clear entry");
        for (int i = 0; i < 4; i++) begin
            drive(1'b0, 1'b0, 1, "R7");
            drive(1'b1, 1'b0, 1, "R7");
            check("R7 held by clear");
        end
        @(negedge clk);
        clear = 1'b0;
        repeat (4) @(negedge clk);
        check("R7 after release");

        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 5) begin
                do_clear("R1 random clear");
            end else begin
                drive(1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0),
                      0, "R9 random sequence");
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule